// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the byte-level slave engine of a two-wire serial EEPROM. It sits behind a bus condition detector and consumes single-cycle events: START (also repeated START), STOP, SCL rising and SCL falling, plus the sampled SDA level. From these it recognises its select byte and collects a two-byte memory address into an internal address counter. It then takes write bytes, or serves read bytes from a byte-wide memory port. Its only effect on the bus is an SDA pull-low output, used for acknowledges and for read data.

Accepted write bytes go to a downstream page buffer as a one-cycle handoff that carries the address and the data. A write-protect input lets select and address bytes be acknowledged while every data byte is refused. Current-address, random-address (dummy write followed by a repeated START) and sequential reads are served from the same counter. The memory read port is combinational: `mem_rdata` must show the byte at `mem_addr` in the same cycle.

Top module: `ees_slave_engine`

## Requirements
- R1: A select byte, sent MSB first, whose bits 7..4 are 1010 and whose bits 3..1 equal `chip_sel[2:0]` is acknowledged: `sda_pull_low` is 1 during the ninth clock. Bit 0 selects the direction (1 = read, 0 = write).
- R2: If the select byte does not match, no acknowledge is given. The engine stays silent (no pull-low) for all later clocks until the next START.
- R3: After a write select, two address bytes are taken (high byte first) and each is acknowledged. Address bits at and above ADDR_W (bit 15 with the default ADDR_W = 15) are ignored. Each acknowledged data byte produces one `wbyte_valid` pulse that carries the current address and the byte.
- R4: After each accepted data byte, only the low PAGE_BITS (default 6) address bits advance. They wrap inside the page, so 0x013F is followed by 0x0100.
- R5: When the latched protect level is 1, select and address bytes are still acknowledged. Every data byte gets NoAck and produces no handoff.
- R6: The protect level is sampled from START until the eighth bit of the second address byte is taken, and the last sample holds. Later changes of `wr_protect` do not alter the acknowledge of data bytes.
- R7: A random read (address loaded by a write select, then a repeated START and a read select) returns the byte at the loaded address, MSB first. A 0 bit is driven as pull-low.
- R8: When the master acknowledges a read byte, the next byte comes from the next consecutive address.
- R9: The read address counter wraps from the last address (0x7FFF by default) to 0.
- R10: A read select with no address phase returns the byte at the counter value left by the previous operation: one past the last byte read.
- R11: Reads work and are acknowledged whatever the level of `wr_protect`.
- R12: When the master gives NoAck on a read byte, the engine stops driving SDA and stays silent until the next START.
- R13: `sda_pull_low` changes only in the cycle after an SCL-falling, START or STOP event. An acknowledge is held through the high phase of the ninth clock and released at its falling edge.
- R14: After reset, SDA is released and no handoff is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_det | input | 1 | One-cycle pulse: STOP seen |
| scl_rise | input | 1 | One-cycle pulse: SCL rising edge, SDA sampled |
| scl_fall | input | 1 | One-cycle pulse: SCL falling edge |
| sda_in | input | 1 | SDA level seen on the bus |
| chip_sel | input | 3 | Pin-strapped select bits compared with select bits 3..1 |
| wr_protect | input | 1 | Write protect level, 1 = data writes refused |
| sda_pull_low | output | 1 | 1 = pull SDA low |
| mem_addr | output | ADDR_W | Read port address (address counter) |
| mem_rdata | input | 8 | Read port data, combinational from mem_addr |
| wbyte_valid | output | 1 | One-cycle handoff of an accepted write byte |
| wbyte_addr | output | ADDR_W | Address of the handed-off byte |
| wbyte_data | output | 8 | Handed-off data byte |

## Verification
Two functions meet on the same SCL falling edge. When a read byte is acknowledged, the counter increment, the load of the next byte from the memory port and the first bit drive all happen at that one edge. When a data byte is accepted, the handoff of the current address and the page-limited increment also share a single edge. The bench provokes the read case with sequential reads across the 0x7FFF boundary, and the write case with three bytes starting at 0x013E. It judges them by the read values, which come from a data pattern computed from the address, and by the addresses of the recorded handoffs, which must be 0x013E, 0x013F and 0x0100.

// File: rtl/ees_pkg.sv
package ees_pkg;
   localparam logic [3:0] TYPE_CODE = 4'b1010;
   localparam int         BYTE_W    = 8;
   localparam int         CNT_W     = 4;
   localparam int         ACK_SLOT  = 9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVSEL,
      ST_ADDR_HI,
      ST_ADDR_LO,
      ST_WDATA,
      ST_RD_FIRST,
      ST_RD_DATA
   } ees_state_t;
endpackage

// File: rtl/ees_bit_rx.sv
module ees_bit_rx
   import ees_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rise,
   input  logic              fall,
   input  logic              sda_in,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              m_ack
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_byte <= '0;
         m_ack   <= 1'b0;
      end else if (clr) begin
         bit_cnt <= '0;
      end else if (rise && (bit_cnt < CNT_W'(ACK_SLOT))) begin
         bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt < CNT_W'(BYTE_W))
            rx_byte <= {rx_byte[BYTE_W-2:0], sda_in};
         else
            m_ack <= ~sda_in;
      end else if (fall && (bit_cnt == CNT_W'(ACK_SLOT))) begin
         bit_cnt <= '0;
      end
   end
endmodule

// File: rtl/ees_addr_ctr.sv
module ees_addr_ctr
   import ees_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int PAGE_BITS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi,
   input  logic              ld_lo,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              inc_rd,
   input  logic              inc_wr,
   output logic [ADDR_W-1:0] addr
);
   localparam int HI_W = ADDR_W - BYTE_W;

   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W-1:0] wr_next;

   generate
      if (HI_W < BYTE_W) begin : g_drop_top
         logic unused_top_bits;
         assign unused_top_bits = ^byte_in[BYTE_W-1:HI_W];
      end
      if (PAGE_BITS == 0) begin : g_no_advance
         assign wr_next = addr;
      end else begin : g_page_advance
         logic [PAGE_BITS-1:0] low_next;
         assign low_next = addr[PAGE_BITS-1:0] + 1'b1;
         assign wr_next  = {addr[ADDR_W-1:PAGE_BITS], low_next};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         addr <= '0;
      end else begin
         if (ld_hi)
            hi_q <= byte_in[HI_W-1:0];
         if (ld_lo)
            addr <= {hi_q, byte_in};
         else if (inc_rd)
            addr <= addr + 1'b1;
         else if (inc_wr)
            addr <= wr_next;
      end
   end
endmodule

// File: rtl/ees_tx_shift.sv
module ees_tx_shift
   import ees_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [BYTE_W-1:0] din,
   output logic              next_bit
);
   logic [BYTE_W-2:0] rest_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rest_q <= '0;
      else if (load)
         rest_q <= din[BYTE_W-2:0];
      else if (shift)
         rest_q <= {rest_q[BYTE_W-3:0], 1'b0};
   end

   assign next_bit = rest_q[BYTE_W-2];
endmodule

// File: rtl/ees_slave_engine.sv
module ees_slave_engine
   import ees_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int PAGE_BITS = 6,
   parameter int SEL_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_in,
   input  logic [SEL_W-1:0]  chip_sel,
   input  logic              wr_protect,
   output logic              sda_pull_low,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              wbyte_valid,
   output logic [ADDR_W-1:0] wbyte_addr,
   output logic [7:0]        wbyte_data
);
   localparam int TYPE_W = BYTE_W - 1 - SEL_W;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ees_slave_engine: ADDR_W must lie in 9..16");
      end
      if (PAGE_BITS < 0 || PAGE_BITS >= ADDR_W) begin : g_bad_page
         $error("ees_slave_engine: PAGE_BITS must lie in 0..ADDR_W-1");
      end
      if (SEL_W != 3) begin : g_bad_sel
         $error("ees_slave_engine: select field must be 3 bits");
      end
   endgenerate

   ees_state_t        state;
   logic              wp_q;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_byte;
   logic              m_ack;
   logic              tx_next;

   logic fall8, fall9, fall_mid;
   logic dev_match, in_window;
   logic ld_hi, ld_lo, wr_take, rd_load, tx_shift;

   assign fall8    = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
   assign fall9    = scl_fall && (bit_cnt == CNT_W'(ACK_SLOT));
   assign fall_mid = scl_fall && (bit_cnt != '0) && (bit_cnt < CNT_W'(BYTE_W));

   assign dev_match = (rx_byte[BYTE_W-1 -: TYPE_W] == TYPE_CODE[TYPE_W-1:0]) &&
                      (rx_byte[SEL_W:1] == chip_sel);
   assign in_window = (state == ST_DEVSEL) || (state == ST_ADDR_HI) || (state == ST_ADDR_LO);

   assign ld_hi    = fall8 && (state == ST_ADDR_HI);
   assign ld_lo    = fall8 && (state == ST_ADDR_LO);
   assign wr_take  = fall8 && (state == ST_WDATA) && !wp_q;
   assign rd_load  = fall9 && ((state == ST_RD_FIRST) || ((state == ST_RD_DATA) && m_ack));
   assign tx_shift = fall_mid && (state == ST_RD_DATA);

   ees_bit_rx u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_det | stop_det),
      .rise    (scl_rise),
      .fall    (scl_fall),
      .sda_in  (sda_in),
      .bit_cnt (bit_cnt),
      .rx_byte (rx_byte),
      .m_ack   (m_ack)
   );

   ees_addr_ctr #(
      .ADDR_W    (ADDR_W),
      .PAGE_BITS (PAGE_BITS)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_hi   (ld_hi),
      .ld_lo   (ld_lo),
      .byte_in (rx_byte),
      .inc_rd  (rd_load),
      .inc_wr  (wr_take),
      .addr    (mem_addr)
   );

   ees_tx_shift u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (rd_load),
      .shift    (tx_shift),
      .din      (mem_rdata),
      .next_bit (tx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         sda_pull_low <= 1'b0;
         wp_q         <= 1'b0;
         wbyte_valid  <= 1'b0;
         wbyte_addr   <= '0;
         wbyte_data   <= '0;
      end else begin
         wbyte_valid <= 1'b0;
         if (start_det) begin
            state        <= ST_DEVSEL;
            sda_pull_low <= 1'b0;
            wp_q         <= wr_protect;
         end else if (stop_det) begin
            state        <= ST_IDLE;
            sda_pull_low <= 1'b0;
         end else begin
            if (in_window)
               wp_q <= wr_protect;
            if (fall8) begin
               case (state)
                  ST_DEVSEL: begin
                     if (dev_match) begin
                        sda_pull_low <= 1'b1;
                        state        <= rx_byte[0] ? ST_RD_FIRST : ST_ADDR_HI;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
                  ST_ADDR_HI: begin
                     sda_pull_low <= 1'b1;
                     state        <= ST_ADDR_LO;
                  end
                  ST_ADDR_LO: begin
                     sda_pull_low <= 1'b1;
                     state        <= ST_WDATA;
                  end
                  ST_WDATA: begin
                     if (!wp_q) begin
                        sda_pull_low <= 1'b1;
                        wbyte_valid  <= 1'b1;
                        wbyte_addr   <= mem_addr;
                        wbyte_data   <= rx_byte;
                     end
                  end
                  default: sda_pull_low <= 1'b0;
               endcase
            end else if (fall9) begin
               if (rd_load) begin
                  sda_pull_low <= ~mem_rdata[BYTE_W-1];
                  state        <= ST_RD_DATA;
               end else begin
                  sda_pull_low <= 1'b0;
                  if (state == ST_RD_DATA)
                     state <= ST_IDLE;
               end
            end else if (tx_shift) begin
               sda_pull_low <= ~tx_next;
            end
         end
      end
   end
endmodule

// File: rtl/ees_engine_chk.sv
module ees_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start_det,
   input logic stop_det,
   input logic scl_fall,
   input logic sda_pull_low,
   input logic wbyte_valid,
   input logic wp_latched,
   input logic in_standby
);
   // R13: the pull-low output moves only after a falling-SCL, START or STOP event
   a_r13_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_low) |-> $past(scl_fall || start_det || stop_det));

   // R5: no handoff while the latched protect level is high
   a_r5_protected_no_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      wbyte_valid |-> !wp_latched);

   // R3: every handoff comes with an acknowledge on the bus
   a_r3_handoff_acked: assert property (@(posedge clk) disable iff (!rst_n)
      wbyte_valid |-> sda_pull_low);

   // R2 and R12: standby never drives the bus
   a_r2_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
      in_standby |-> !sda_pull_low);

   // R12: a START leaves standby with the bus released
   a_r12_start_release: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_pull_low && !in_standby));
endmodule

bind ees_slave_engine ees_engine_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_det    (start_det),
   .stop_det     (stop_det),
   .scl_fall     (scl_fall),
   .sda_pull_low (sda_pull_low),
   .wbyte_valid  (wbyte_valid),
   .wp_latched   (wp_q),
   .in_standby   (state == ees_pkg::ST_IDLE)
);

// File: tb/tb_ees_slave_engine.sv
module tb_ees_slave_engine;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_det = 1'b0, stop_det = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
   logic m_sda = 1'b1;
   logic sda_in;
   logic [2:0] chip_sel = 3'b101;
   logic wr_protect = 1'b0;
   logic sda_pull_low;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0] mem_rdata;
   logic wbyte_valid;
   logic [ADDR_W-1:0] wbyte_addr;
   logic [7:0] wbyte_data;

   int checks = 0, errors = 0, hcnt = 0;
   logic [ADDR_W-1:0] ha [0:3];
   logic [7:0]        hd [0:3];
   bit done = 0;

   localparam logic [7:0] SEL_WR = 8'hAA;
   localparam logic [7:0] SEL_RD = 8'hAB;

   always #(CLK_P/2) clk = ~clk;
   assign sda_in = m_sda & ~sda_pull_low;

   function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
      return a[7:0] ^ {1'b0, a[14:8]};
   endfunction
   assign mem_rdata = pat(mem_addr);

   ees_slave_engine #(.ADDR_W(ADDR_W), .PAGE_BITS(6), .SEL_W(3)) dut (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
      .chip_sel(chip_sel), .wr_protect(wr_protect), .sda_pull_low(sda_pull_low),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wbyte_valid(wbyte_valid),
      .wbyte_addr(wbyte_addr), .wbyte_data(wbyte_data)
   );

   always @(posedge clk) if (wbyte_valid) begin
      ha[hcnt % 4] <= wbyte_addr;
      hd[hcnt % 4] <= wbyte_data;
      hcnt <= hcnt + 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_start(); m_sda = 1'b1; pulse(start_det); endtask
   task automatic do_stop();  pulse(stop_det); endtask

   task automatic clk_bit(input logic b, output logic seen);
      @(negedge clk) m_sda = b;
      pulse(scl_rise);
      seen = sda_pull_low;
      pulse(scl_fall);
   endtask

   task automatic send8(input logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      send8(v);
      clk_bit(1'b1, ack);
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = ~s;
      end
      clk_bit(give_ack ? 1'b0 : 1'b1, s);
   endtask

   task automatic t_reset();
      chk(sda_pull_low == 1'b0, "R14 sda released", sda_pull_low, 0);
      chk(hcnt == 0 && wbyte_valid == 1'b0, "R14 no handoff", hcnt, 0);
   endtask

   task automatic t_select();
      logic a;
      do_start();
      send8(SEL_WR);
      chk(sda_pull_low == 1'b1, "R13 ack driven after eighth fall", sda_pull_low, 1);
      clk_bit(1'b1, a);
      chk(a == 1'b1, "R1 matching select acked", a, 1);
      chk(sda_pull_low == 1'b0, "R13 ack released after ninth fall", sda_pull_low, 0);
      do_stop();
      do_start();
      send_byte(8'hBA, a);
      chk(a == 1'b0, "R2 wrong type code not acked", a, 0);
      send_byte(8'h00, a);
      chk(a == 1'b0, "R2 later byte ignored in standby", a, 0);
      do_stop();
      do_start();
      send_byte(8'hA2, a);
      chk(a == 1'b0, "R2 wrong chip bits not acked", a, 0);
      do_stop();
   endtask

   task automatic t_write();
      logic a;
      int base;
      wr_protect = 1'b0;
      do_start();
      send_byte(SEL_WR, a);
      send_byte(8'h81, a);
      chk(a == 1'b1, "R3 high address acked", a, 1);
      send_byte(8'h22, a);
      chk(a == 1'b1, "R3 low address acked", a, 1);
      base = hcnt;
      send_byte(8'h5C, a);
      chk(a == 1'b1, "R3 data acked", a, 1);
      do_stop();
      chk(hcnt == base + 1, "R3 one handoff", hcnt, base + 1);
      chk(ha[base % 4] == 15'h0122, "R3 top bit ignored", ha[base % 4], 15'h0122);
      chk(hd[base % 4] == 8'h5C, "R3 data handed off", hd[base % 4], 8'h5C);
      do_start();
      send_byte(SEL_WR, a);
      send_byte(8'h01, a);
      send_byte(8'h3E, a);
      base = hcnt;
      send_byte(8'h11, a);
      send_byte(8'h22, a);
      send_byte(8'h33, a);
      do_stop();
      chk(hcnt == base + 3, "R4 three handoffs", hcnt, base + 3);
      chk(ha[base % 4] == 15'h013E, "R4 first addr", ha[base % 4], 15'h013E);
      chk(ha[(base + 1) % 4] == 15'h013F, "R4 second addr", ha[(base + 1) % 4], 15'h013F);
      chk(ha[(base + 2) % 4] == 15'h0100, "R4 page wrap", ha[(base + 2) % 4], 15'h0100);
      chk(hd[(base + 2) % 4] == 8'h33, "R4 wrap data", hd[(base + 2) % 4], 8'h33);
   endtask

   task automatic t_protect();
      logic a1, a2, a3, a4;
      int base;
      wr_protect = 1'b1;
      base = hcnt;
      do_start();
      send_byte(SEL_WR, a1);
      send_byte(8'h02, a2);
      send_byte(8'h00, a3);
      send_byte(8'h99, a4);
      do_stop();
      chk(a1 && a2 && a3, "R5 select and address acked", {a1, a2, a3}, 3'b111);
      chk(a4 == 1'b0, "R5 data refused", a4, 0);
      chk(hcnt == base, "R5 no handoff", hcnt, base);
      wr_protect = 1'b0;
      do_start();
      send_byte(SEL_WR, a1);
      send_byte(8'h02, a1);
      send_byte(8'h00, a1);
      wr_protect = 1'b1;
      send_byte(8'h77, a4);
      do_stop();
      chk(a4 == 1'b1, "R6 late raise ignored", a4, 1);
      chk(hcnt == base + 1, "R6 handoff after late raise", hcnt, base + 1);
      do_start();
      send_byte(SEL_WR, a1);
      send_byte(8'h02, a1);
      send_byte(8'h00, a1);
      wr_protect = 1'b0;
      send_byte(8'h66, a4);
      do_stop();
      chk(a4 == 1'b0, "R6 late drop ignored", a4, 0);
      chk(hcnt == base + 1, "R6 no handoff after late drop", hcnt, base + 1);
   endtask

   task automatic t_rand_read();
      logic a;
      logic [7:0] d;
      do_start();
      send_byte(SEL_WR, a);
      send_byte(8'h12, a);
      send_byte(8'h34, a);
      do_start();
      send_byte(SEL_RD, a);
      chk(a == 1'b1, "R7 read select acked", a, 1);
      read_byte(1'b0, d);
      do_stop();
      chk(d == pat(15'h1234), "R7 random read data", d, pat(15'h1234));
   endtask

   task automatic t_seq_wrap();
      logic a;
      logic [7:0] d0, d1, d2;
      do_start();
      send_byte(SEL_WR, a);
      send_byte(8'h7F, a);
      send_byte(8'hFE, a);
      do_start();
      send_byte(SEL_RD, a);
      read_byte(1'b1, d0);
      read_byte(1'b1, d1);
      read_byte(1'b0, d2);
      do_stop();
      chk(d0 == pat(15'h7FFE), "R8 first sequential", d0, pat(15'h7FFE));
      chk(d1 == pat(15'h7FFF), "R8 next sequential", d1, pat(15'h7FFF));
      chk(d2 == pat(15'h0000), "R9 wrap to zero", d2, pat(15'h0000));
   endtask

   task automatic t_current();
      logic a;
      logic [7:0] d;
      do_start();
      send_byte(SEL_RD, a);
      read_byte(1'b0, d);
      do_stop();
      chk(a == 1'b1 && d == pat(15'h0001), "R10 current address read", d, pat(15'h0001));
   endtask

   task automatic t_read_wp();
      logic a;
      logic [7:0] d;
      wr_protect = 1'b1;
      do_start();
      send_byte(SEL_RD, a);
      read_byte(1'b0, d);
      do_stop();
      wr_protect = 1'b0;
      chk(a == 1'b1, "R11 read select acked under protect", a, 1);
      chk(d == pat(15'h0002), "R11 read data under protect", d, pat(15'h0002));
   endtask

   task automatic t_nack_release();
      logic a, s;
      logic [7:0] d;
      int seen = 0;
      do_start();
      send_byte(SEL_WR, a);
      send_byte(8'h00, a);
      send_byte(8'h00, a);
      do_start();
      send_byte(SEL_RD, a);
      read_byte(1'b0, d);
      chk(d == 8'h00, "R12 zero byte read", d, 0);
      for (int i = 0; i < 9; i++) begin
         clk_bit(1'b1, s);
         if (s) seen++;
      end
      chk(seen == 0 && sda_pull_low == 1'b0, "R12 silent after NoAck", seen, 0);
      do_stop();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_write();
      t_protect();
      t_rand_read();
      t_seq_wrap();
      t_current();
      t_read_wp();
      t_nack_release();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule